// File: doc/BRIEF.md
# BCD Seven-Segment Latching Decoder

This block turns a 4-bit binary-coded-decimal digit into the seven active-high segment enables of a numeric display. A storage register holds the digit. While the hold input is low the register takes a new digit on every clock edge. While the hold input is high the register keeps the digit it last took, so the display stays steady even if the data bus is reused for something else.

Two active-low controls act on the decoded glyph. Lamp test lights every segment and overrides everything else, blanking included. Blanking turns every segment off. Blanking can be driven from outside with a pulse-width signal to dim the display. Input codes 10 to 15 also give a dark display, which offers a second way to blank it. The digits 6 and 9 are drawn without their top and bottom tails.

A parameter chooses whether the segment outputs come from a register or straight from the override logic. With the default, the outputs are registered.

Top module: `bcdseg_latch_decoder`

## Requirements
- R1: While `lamp_test_n` is 0, `seg_out` is 7'h7F, whatever the hold, blanking and data inputs are.
- R2: While `lamp_test_n` is 1 and `blank_n` is 0, `seg_out` is 7'h00.
- R3: With both controls at 1, a stored digit 0..9 gives these `seg_out` values (bit 0 = segment a, up to bit 6 = segment g): 0→3F, 1→06, 2→5B, 3→4F, 4→66, 5→6D, 6→7C, 7→07, 8→7F, 9→67.
- R4: With both controls at 1, a stored code from 10 to 15 gives `seg_out` = 7'h00.
- R5: The 4-bit input `bcd_in` uses 8421 weighting, with bit 0 as the least significant bit. On every rising clock edge at which `latch_hold` is 0, the stored code takes the value of `bcd_in`.
- R6: On every rising clock edge at which `latch_hold` is 1, the stored code keeps its value. Changes on `bcd_in` do not reach `seg_out`.
- R7: `rst` is an active-high synchronous reset. It clears the stored code to 0 and the segment register to 7'h00. After reset, with hold high and both controls at 1, the display shows the digit 0.
- R8: With `REG_OUT`=1, a change on `lamp_test_n` or `blank_n` reaches `seg_out` after one rising edge. A new digit on `bcd_in` reaches `seg_out` after two rising edges: one for the code register and one for the segment register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| latch_hold | input | 1 | 1 = keep the stored code, 0 = load on every edge |
| lamp_test_n | input | 1 | Active-low lamp test, all segments on |
| blank_n | input | 1 | Active-low blanking, all segments off |
| bcd_in | input | 4 | BCD code, bit 0 least significant |
| seg_out | output | 7 | Segment enables, bit 0 = a through bit 6 = g |

## Verification
With the default registered output, the controls reach the segments one rising edge after they change. A digit on `bcd_in` needs two edges: one into the code register and one into the segment register. Most checks drive the inputs on a falling edge, let two rising edges pass, and compare on the next falling edge, so both paths have settled. A dedicated latency sequence samples one falling edge after a change. It expects lamp test to show already, and the new digit to still show the old glyph, with the new glyph one edge later. The hold checks change `bcd_in` while hold is high and expect the earlier glyph after the same two-edge wait.

// File: rtl/bcdseg_pkg.sv
package bcdseg_pkg;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned SEG_W  = 7;
  localparam logic [SEG_W-1:0] SEG_ALL_ON  = {SEG_W{1'b1}};
  localparam logic [SEG_W-1:0] SEG_ALL_OFF = {SEG_W{1'b0}};

  // bit 0 = segment a ... bit 6 = segment g
  function automatic logic [SEG_W-1:0] digit_glyph(input logic [CODE_W-1:0] v);
    logic [SEG_W-1:0] g;
    case (v)
      4'd0:    g = 7'h3F;
      4'd1:    g = 7'h06;
      4'd2:    g = 7'h5B;
      4'd3:    g = 7'h4F;
      4'd4:    g = 7'h66;
      4'd5:    g = 7'h6D;
      4'd6:    g = 7'h7C;
      4'd7:    g = 7'h07;
      4'd8:    g = 7'h7F;
      4'd9:    g = 7'h67;
      default: g = SEG_ALL_OFF;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/bcdseg_code_reg.sv
module bcdseg_code_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (!hold) q <= d;
  end

  AST_LOAD_WHEN_OPEN: assert property (@(posedge clk) disable iff (rst)
    !hold |=> q == $past(d)); // R5
  AST_KEEP_WHEN_HELD: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(q)); // R6
  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> q == '0); // R7
endmodule

// File: rtl/bcdseg_glyph_dec.sv
module bcdseg_glyph_dec
  import bcdseg_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [SEG_W-1:0]  glyph
);
  always_comb glyph = digit_glyph(code);
endmodule

// File: rtl/bcdseg_override.sv
module bcdseg_override
  import bcdseg_pkg::*;
(
  input  logic             lamp_n,
  input  logic             dark_n,
  input  logic [SEG_W-1:0] glyph,
  output logic [SEG_W-1:0] seg
);
  // lamp test wins over blanking, blanking wins over the glyph
  always_comb begin
    if (!lamp_n)      seg = SEG_ALL_ON;
    else if (!dark_n) seg = SEG_ALL_OFF;
    else              seg = glyph;
  end
endmodule

// File: rtl/bcdseg_latch_decoder.sv
module bcdseg_latch_decoder
  import bcdseg_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch_hold,
  input  logic              lamp_test_n,
  input  logic              blank_n,
  input  logic [CODE_W-1:0] bcd_in,
  output logic [SEG_W-1:0]  seg_out
);
  logic [CODE_W-1:0] code_q;
  logic [SEG_W-1:0]  glyph;
  logic [SEG_W-1:0]  seg_next;

  bcdseg_code_reg #(.W(CODE_W)) u_code (
    .clk(clk), .rst(rst), .hold(latch_hold), .d(bcd_in), .q(code_q)
  );

  bcdseg_glyph_dec u_dec (.code(code_q), .glyph(glyph));

  bcdseg_override u_ovr (
    .lamp_n(lamp_test_n), .dark_n(blank_n), .glyph(glyph), .seg(seg_next)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic [SEG_W-1:0] seg_q;
      always_ff @(posedge clk) begin
        if (rst) seg_q <= SEG_ALL_OFF;
        else     seg_q <= seg_next;
      end
      assign seg_out = seg_q;

      AST_LAMP_ALL_ON: assert property (@(posedge clk) disable iff (rst)
        !lamp_test_n |=> seg_out == SEG_ALL_ON); // R1
      AST_BLANK_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        (lamp_test_n && !blank_n) |=> seg_out == SEG_ALL_OFF); // R2
      AST_HIGH_CODE_DARK: assert property (@(posedge clk) disable iff (rst)
        (lamp_test_n && blank_n && code_q > 4'd9) |=> seg_out == SEG_ALL_OFF); // R4
      AST_RESET_SEG_DARK: assert property (@(posedge clk)
        rst |=> seg_out == SEG_ALL_OFF); // R7
    end else begin : g_comb
      assign seg_out = seg_next;

      AST_LAMP_ALL_ON: assert property (@(posedge clk) disable iff (rst)
        !lamp_test_n |-> seg_out == SEG_ALL_ON); // R1
      AST_BLANK_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        (lamp_test_n && !blank_n) |-> seg_out == SEG_ALL_OFF); // R2
      AST_HIGH_CODE_DARK: assert property (@(posedge clk) disable iff (rst)
        (lamp_test_n && blank_n && code_q > 4'd9) |-> seg_out == SEG_ALL_OFF); // R4
    end
  endgenerate
endmodule

// File: tb/bcdseg_latch_decoder_tb.sv
`timescale 1ns/1ps
module bcdseg_latch_decoder_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       latch_hold;
  logic       lamp_test_n;
  logic       blank_n;
  logic [3:0] bcd_in;
  logic [6:0] seg_out;

  int n_cmp = 0;
  int n_bad = 0;
  logic [3:0] stored;

  always #2.5 clk = ~clk;

  bcdseg_latch_decoder u_dut (
    .clk(clk), .rst(rst), .latch_hold(latch_hold), .lamp_test_n(lamp_test_n),
    .blank_n(blank_n), .bcd_in(bcd_in), .seg_out(seg_out)
  );

  function automatic logic [6:0] glyph_of(input logic [3:0] v);
    case (v)
      4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B;
      4'd3: return 7'h4F; 4'd4: return 7'h66; 4'd5: return 7'h6D;
      4'd6: return 7'h7C; 4'd7: return 7'h07; 4'd8: return 7'h7F;
      4'd9: return 7'h67;
      default: return 7'h00;
    endcase
  endfunction

  function automatic logic [6:0] expect_seg(input logic lt, input logic bl, input logic [3:0] v);
    if (!lt) return 7'h7F;
    if (!bl) return 7'h00;
    return glyph_of(v);
  endfunction

  task automatic check(input string tag, input logic [6:0] exp);
    n_cmp++;
    if (seg_out !== exp) begin
      n_bad++;
      $display("FAIL %s: seg_out=%h expected=%h", tag, seg_out, exp);
    end
  endtask

  task automatic drive(input logic le, input logic lt, input logic bl, input logic [3:0] d);
    @(negedge clk);
    latch_hold = le; lamp_test_n = lt; blank_n = bl; bcd_in = d;
    if (!le) stored = d;
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4511));
    rst = 1'b1; latch_hold = 1'b1; lamp_test_n = 1'b1; blank_n = 1'b1; bcd_in = 4'd7;
    stored = 4'd0;
    settle();
    check("R7 seg dark in reset", 7'h00);
    @(negedge clk); rst = 1'b0;
    settle();
    check("R7 digit 0 after reset", 7'h3F);

    // exhaustive sweep over controls and codes
    for (int lt = 0; lt < 2; lt++)
      for (int bl = 0; bl < 2; bl++)
        for (int c = 0; c < 16; c++) begin
          drive(1'b0, lt[0], bl[0], c[3:0]);
          settle();
          if (lt == 0)      check("R1 lamp test", expect_seg(lt[0], bl[0], c[3:0]));
          else if (bl == 0) check("R2 blanking", expect_seg(lt[0], bl[0], c[3:0]));
          else if (c < 10)  check("R3 digit glyph", expect_seg(lt[0], bl[0], c[3:0]));
          else              check("R4 high code dark", expect_seg(lt[0], bl[0], c[3:0]));
        end

    // hold survives data changes
    drive(1'b0, 1'b1, 1'b1, 4'd6);
    settle();
    check("R5 load 6", 7'h7C);
    drive(1'b1, 1'b1, 1'b1, 4'd9);
    settle();
    check("R6 held 6 vs 9", 7'h7C);
    drive(1'b1, 1'b1, 1'b1, 4'd12);
    settle();
    check("R6 held 6 vs 12", 7'h7C);
    drive(1'b1, 1'b0, 1'b1, 4'd3);
    settle();
    check("R1 lamp over held", 7'h7F);

    // latency
    drive(1'b0, 1'b1, 1'b1, 4'd5);
    settle();
    check("R8 base 5", 7'h6D);
    @(negedge clk); lamp_test_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R8 lamp after one edge", 7'h7F);
    lamp_test_n = 1'b1; bcd_in = 4'd1; stored = 4'd1;
    @(posedge clk); @(negedge clk);
    check("R8 digit still old after one edge", 7'h6D);
    @(posedge clk); @(negedge clk);
    check("R8 digit new after two edges", 7'h06);

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic le, lt, bl;
      logic [3:0] d;
      le = ($urandom % 3) == 0;
      lt = ($urandom % 6) != 0;
      bl = ($urandom % 5) != 0;
      d  = 4'($urandom % 16);
      drive(le, lt, bl, d);
      settle();
      if (!lt)      check("R1 random", expect_seg(lt, bl, stored));
      else if (!bl) check("R2 random", expect_seg(lt, bl, stored));
      else if (le)  check("R6 random hold", expect_seg(lt, bl, stored));
      else          check("R5 random load", expect_seg(lt, bl, stored));
    end

    // reset while held clears code
    drive(1'b0, 1'b1, 1'b1, 4'd8);
    settle();
    @(negedge clk); rst = 1'b1; latch_hold = 1'b1;
    settle();
    check("R7 dark in second reset", 7'h00);
    @(negedge clk); rst = 1'b0;
    settle();
    check("R7 code cleared to 0", 7'h3F);

    finish_run();
  end
endmodule